// File: doc/BRIEF.md
# Quadrature Motion Accumulator with Report Events

This block sits behind a quadrature sampling stage and consumes its stream of per-sample motion codes. Each code says whether the last sample pair showed no motion, one step forward, one step back, or an illegal double transition. The block keeps a signed net-displacement counter and a small saturating counter of double transitions. It also counts samples toward a programmable report period. At the end of each period it raises a report-ready event when motion has built up and a double-ready event when errors have built up.

Software or an event fabric can ask for either counter, or both, to be read and cleared. Each request copies the selected counter into its snapshot register and zeroes the counter in the same clock edge. Shortcut enables let the block's own events raise these clear requests, so a report can be captured and restarted without software in the loop.

The code input is a valid/ready stream. The block never applies back-pressure: `in_ready` is high whenever reset is released, and a code counts on every clock edge where `in_valid` is high. The upstream stage therefore never has to stall or hold a code.

Top module: `motion_accum`

## Requirements
- R1: The code encoding is 2'b00 for no motion, 2'b01 for +1 and 2'b11 for -1. A +1 or -1 code changes the signed displacement counter (range -1024..1023) by that amount on the edge that accepts it, and a 2'b00 code leaves the counter unchanged.
- R2: Code 2'b10 (double transition) never changes the displacement counter. It increments the 4-bit error counter.
- R3: A +1 at 1023 or a -1 at -1024 is discarded and the counter keeps its value. The next cycle carries a one-cycle `ev_overflow` pulse. Later in-range codes are still applied.
- R4: The error counter stops at 15. A double transition that arrives while it is at 15 raises `ev_overflow`.
- R5: The `report_sel` code gives the number of samples in one report period: 0 gives 10, 1 through 7 give 40 times the code (40..280), and 8 or above give 1.
- R6: Each accepted sample that completes a period is followed one cycle later by an `ev_report` pulse if the updated displacement counter is nonzero. It is likewise followed by an `ev_double` pulse if the updated error counter is nonzero.
- R7: `clr_both` copies both counters into their snapshots and zeroes them. `clr_disp` does this for the displacement counter only, and `clr_err` for the error counter only. A snapshot changes only when its counter is cleared.
- R8: In the cycle where `ev_report` is high, `sc_report_both` requests a clear of both counters and `sc_report_disp` requests a clear of displacement only. In the cycle where `ev_double` is high, `sc_double_err` requests a clear of errors. Each such clear takes effect on the following edge.
- R9: A code accepted on the same edge as a clear is applied to the zeroed counter, so it is not lost.
- R10: `start` restarts the sample count of the report period. A code accepted on the same edge counts as the first sample of the new period.
- R11: `in_ready` is high whenever reset is not asserted.
- R12: After reset, both counters, both snapshots and all event outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Restart the report-period sample count |
| in_valid | input | 1 | Motion code is present |
| in_ready | output | 1 | Block accepts codes (always when out of reset) |
| in_code | input | 2 | Motion code: 00 none, 01 +1, 11 -1, 10 double |
| report_sel | input | 4 | Report period selection code |
| clr_both | input | 1 | Snapshot and clear both counters |
| clr_disp | input | 1 | Snapshot and clear the displacement counter |
| clr_err | input | 1 | Snapshot and clear the error counter |
| sc_report_both | input | 1 | Report event clears both counters |
| sc_report_disp | input | 1 | Report event clears displacement |
| sc_double_err | input | 1 | Double event clears errors |
| disp | output | 11 | Signed net displacement |
| errs | output | 4 | Double-transition count |
| disp_snap | output | 11 | Displacement snapshot |
| errs_snap | output | 4 | Error-count snapshot |
| ev_report | output | 1 | Report-ready pulse |
| ev_double | output | 1 | Double-ready pulse |
| ev_overflow | output | 1 | Discarded step or saturated error pulse |

## Verification
The embedded assertions watch the local invariants on every cycle. The displacement counter holds its value at each limit when pushed outward, and the error counter stays at 15 under further double transitions. Each snapshot equals the counter value from just before its clear. A report or double event never appears with a zero counter, and a start with no sample leaves the period count at zero. Only the bench scenarios can show the period lengths selected by each `report_sel` code, the exact cycle on which events fire across whole periods, and the order of shortcut clears relative to later samples. They also show that a sample arriving with a clear is kept.

// File: rtl/motion_pkg.sv
package motion_pkg;

  localparam int PER_W = 9;

  typedef enum logic [1:0] {
    MC_NONE = 2'b00,
    MC_FWD  = 2'b01,
    MC_DBL  = 2'b10,
    MC_REV  = 2'b11
  } mcode_t;

  // samples per report period for a selection code
  function automatic logic [PER_W-1:0] period_len(input logic [3:0] sel);
    logic [PER_W-1:0] r;
    if (sel == 4'd0)
      r = PER_W'(10);
    else if (sel <= 4'd7)
      r = PER_W'(sel) * PER_W'(40);
    else
      r = PER_W'(1);
    return r;
  endfunction

endpackage

// File: rtl/mac_disp_acc.sv
module mac_disp_acc #(
  parameter int W = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_up,
  input  logic                step_dn,
  input  logic                clear,
  output logic signed [W-1:0] value,
  output logic signed [W-1:0] snap,
  output logic signed [W-1:0] next_value,
  output logic                drop
);

  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic signed [W-1:0] base;

  always_comb begin
    base       = clear ? '0 : value;
    next_value = base;
    drop       = 1'b0;
    if (step_up) begin
      if (base == MAXV) drop = 1'b1;
      else              next_value = base + ONE;
    end else if (step_dn) begin
      if (base == MINV) drop = 1'b1;
      else              next_value = base - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= '0;
      snap  <= '0;
    end else begin
      value <= next_value;
      if (clear) snap <= value;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !clear && value == MAXV) |=> (value == MAXV));

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && !clear && value == MINV) |=> (value == MINV));

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_up && !step_dn && !clear) |=> $stable(value));

  assert_disp_snap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (snap == $past(value)));

endmodule

// File: rtl/mac_err_acc.sv
module mac_err_acc #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit,
  input  logic         clear,
  output logic [W-1:0] count,
  output logic [W-1:0] snap,
  output logic [W-1:0] next_count,
  output logic         sat_hit
);

  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] base;

  always_comb begin
    base       = clear ? '0 : count;
    next_count = base;
    sat_hit    = 1'b0;
    if (hit) begin
      if (base == TOP) sat_hit = 1'b1;
      else             next_count = base + W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      snap  <= '0;
    end else begin
      count <= next_count;
      if (clear) snap <= count;
    end
  end

  assert_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !clear && count == TOP) |=> (count == TOP));

  assert_err_snap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (snap == $past(count)));

  assert_err_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !clear) |=> $stable(count));

endmodule

// File: rtl/mac_period.sv
module mac_period
  import motion_pkg::*;
#(
  parameter int PW = PER_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       smp_valid,
  input  logic [3:0] sel,
  output logic       period_end
);

  logic [PW-1:0] cnt;
  logic [PW-1:0] base;
  logic [PW-1:0] len;

  always_comb begin
    len        = PW'(period_len(sel));
    base       = restart ? '0 : cnt;
    period_end = smp_valid && (base >= len - PW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (period_end) cnt <= '0;
    else if (smp_valid)  cnt <= base + PW'(1);
    else                 cnt <= base;
  end

  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !smp_valid) |=> (cnt == '0));

  assert_end_wraps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> (cnt == '0));

endmodule

// File: rtl/motion_accum.sv
module motion_accum
  import motion_pkg::*;
#(
  parameter int DISP_W = 11,
  parameter int ERR_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [1:0]               in_code,
  input  logic [3:0]               report_sel,
  input  logic                     clr_both,
  input  logic                     clr_disp,
  input  logic                     clr_err,
  input  logic                     sc_report_both,
  input  logic                     sc_report_disp,
  input  logic                     sc_double_err,
  output logic signed [DISP_W-1:0] disp,
  output logic [ERR_W-1:0]         errs,
  output logic signed [DISP_W-1:0] disp_snap,
  output logic [ERR_W-1:0]         errs_snap,
  output logic                     ev_report,
  output logic                     ev_double,
  output logic                     ev_overflow
);

  mcode_t code;
  logic   take;
  logic   step_up, step_dn, dbl_hit;
  logic   kill_disp, kill_err;
  logic   per_end, drop, sat_hit;
  logic signed [DISP_W-1:0] disp_nx;
  logic [ERR_W-1:0]         errs_nx;

  always_comb begin
    in_ready  = rst_n;
    take      = in_valid && in_ready;
    code      = mcode_t'(in_code);
    step_up   = take && (code == MC_FWD);
    step_dn   = take && (code == MC_REV);
    dbl_hit   = take && (code == MC_DBL);
    kill_disp = clr_both || clr_disp ||
                (ev_report && (sc_report_both || sc_report_disp));
    kill_err  = clr_both || clr_err ||
                (ev_report && sc_report_both) ||
                (ev_double && sc_double_err);
  end

  mac_disp_acc #(.W(DISP_W)) u_disp (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_up    (step_up),
    .step_dn    (step_dn),
    .clear      (kill_disp),
    .value      (disp),
    .snap       (disp_snap),
    .next_value (disp_nx),
    .drop       (drop)
  );

  mac_err_acc #(.W(ERR_W)) u_err (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit        (dbl_hit),
    .clear      (kill_err),
    .count      (errs),
    .snap       (errs_snap),
    .next_count (errs_nx),
    .sat_hit    (sat_hit)
  );

  mac_period u_per (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (start),
    .smp_valid  (take),
    .sel        (report_sel),
    .period_end (per_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_report   <= 1'b0;
      ev_double   <= 1'b0;
      ev_overflow <= 1'b0;
    end else begin
      ev_report   <= per_end && (disp_nx != '0);
      ev_double   <= per_end && (errs_nx != '0);
      ev_overflow <= drop || sat_hit;
    end
  end

  assert_report_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_report |-> (disp != '0));

  assert_double_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_double |-> (errs != '0));

  assert_shortcut_disp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_report && sc_report_disp && !in_valid) |=> (disp == '0));

  assert_shortcut_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_double && sc_double_err && !in_valid) |=> (errs == '0));

  assert_dbl_keeps_disp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dbl_hit && !kill_disp) |=> $stable(disp));

  assert_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);

endmodule

// File: tb/sim_motion_accum.sv
`timescale 1ns/1ps
module sim_motion_accum;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, in_valid = 1'b0, in_ready;
  logic [1:0] in_code = 2'b00;
  logic [3:0] report_sel = 4'd0;
  logic clr_both = 1'b0, clr_disp = 1'b0, clr_err = 1'b0;
  logic sc_report_both = 1'b0, sc_report_disp = 1'b0, sc_double_err = 1'b0;
  logic signed [10:0] disp, disp_snap;
  logic [3:0] errs, errs_snap;
  logic ev_report, ev_double, ev_overflow;

  always #2.5 clk = ~clk;

  motion_accum u0 (.*);

  int total = 0, fails = 0;
  bit done = 1'b0;

  int m_disp = 0, m_err = 0, m_dsnap = 0, m_esnap = 0, m_cnt = 0;
  bit m_evr = 0, m_evd = 0, m_evo = 0;

  task automatic chk(input string tag, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic int plen(input int s);
    if (s == 0) return 10;
    if (s <= 7) return 40 * s;
    return 1;
  endfunction

  // one clock of stimulus, then compare every output
  task automatic step(input bit v, input logic [1:0] c, input bit cb, input bit cd,
                      input bit ce, input bit st, input string tag);
    bit kd, ke, pe;
    int bd, be, bc;
    in_valid = v; in_code = c; clr_both = cb; clr_disp = cd; clr_err = ce; start = st;
    kd = cb || cd || (m_evr && (sc_report_both || sc_report_disp));
    ke = cb || ce || (m_evr && sc_report_both) || (m_evd && sc_double_err);
    bd = kd ? 0 : m_disp;
    be = ke ? 0 : m_err;
    if (kd) m_dsnap = m_disp;
    if (ke) m_esnap = m_err;
    m_evo = 0;
    if (v && c == 2'b01) begin if (bd == 1023) m_evo = 1; else bd++; end
    if (v && c == 2'b11) begin if (bd == -1024) m_evo = 1; else bd--; end
    if (v && c == 2'b10) begin if (be == 15) m_evo = 1; else be++; end
    bc = st ? 0 : m_cnt;
    pe = v && (bc >= plen(int'(report_sel)) - 1);
    m_cnt = pe ? 0 : (v ? bc + 1 : bc);
    m_disp = bd; m_err = be;
    m_evr = pe && (bd != 0);
    m_evd = pe && (be != 0);
    @(posedge clk);
    @(negedge clk);
    chk(tag, "disp", int'(disp), m_disp);
    chk(tag, "errs", int'(errs), m_err);
    chk(tag, "disp_snap", int'(disp_snap), m_dsnap);
    chk(tag, "errs_snap", int'(errs_snap), m_esnap);
    chk(tag, "ev_report", int'(ev_report), int'(m_evr));
    chk(tag, "ev_double", int'(ev_double), int'(m_evd));
    chk(tag, "ev_overflow", int'(ev_overflow), int'(m_evo));
    in_valid = 0; clr_both = 0; clr_disp = 0; clr_err = 0; start = 0;
  endtask

  function automatic logic [1:0] pat(input int i);
    if (i % 7 == 3) return 2'b10;
    case (i % 4)
      0: return 2'b01;
      1: return 2'b11;
      2: return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state, R11 ready
    chk("R12", "disp", int'(disp), 0);
    chk("R12", "errs", int'(errs), 0);
    chk("R12", "snaps", int'(disp_snap) + int'(errs_snap), 0);
    chk("R12", "events", int'(ev_report) + int'(ev_double) + int'(ev_overflow), 0);
    chk("R11", "in_ready", int'(in_ready), 1);

    // R1: mixed steps, long period so events stay quiet
    report_sel = 4'd7;
    for (int i = 0; i < 40; i++) step(1, (i % 3 == 0) ? 2'b11 : ((i % 3 == 1) ? 2'b01 : 2'b00), 0, 0, 0, 0, "R1");
    for (int i = 0; i < 12; i++) step(1, 2'b01, 0, 0, 0, 0, "R1");
    step(0, 2'b01, 0, 0, 0, 0, "R1"); // invalid code ignored

    // R2: double transitions leave displacement alone
    for (int i = 0; i < 5; i++) step(1, 2'b10, 0, 0, 0, 0, "R2");

    // R7: each clear kind
    step(0, 2'b00, 0, 0, 1, 0, "R7");
    step(1, 2'b10, 0, 0, 0, 0, "R7");
    step(0, 2'b00, 0, 1, 0, 0, "R7");
    step(1, 2'b11, 0, 0, 0, 0, "R7");
    step(0, 2'b00, 1, 0, 0, 0, "R7");
    step(0, 2'b00, 0, 0, 0, 0, "R7");

    // R9: sample on the clear edge is kept
    step(1, 2'b01, 0, 0, 0, 0, "R9");
    step(1, 2'b01, 0, 1, 0, 0, "R9");
    step(1, 2'b10, 0, 0, 0, 0, "R9");
    step(1, 2'b10, 0, 0, 1, 0, "R9");
    step(1, 2'b11, 1, 0, 0, 0, "R9");

    // R3: run into both limits
    step(0, 2'b00, 1, 0, 0, 0, "R3");
    for (int i = 0; i < 1030; i++) step(1, 2'b01, 0, 0, 0, 0, "R3");
    for (int i = 0; i < 3; i++) step(1, 2'b11, 0, 0, 0, 0, "R3");
    step(0, 2'b00, 1, 0, 0, 0, "R3");
    for (int i = 0; i < 1030; i++) step(1, 2'b11, 0, 0, 0, 0, "R3");
    step(1, 2'b01, 0, 0, 0, 0, "R3");

    // R4: error saturation
    step(0, 2'b00, 1, 0, 0, 0, "R4");
    for (int i = 0; i < 20; i++) step(1, 2'b10, 0, 0, 0, 0, "R4");
    step(0, 2'b00, 1, 0, 0, 0, "R4");

    // R5 and R6: sweep every period code with idle gaps
    for (int s = 0; s <= 9; s++) begin
      report_sel = 4'(s);
      step(0, 2'b00, 1, 0, 0, 1, "R5");
      for (int i = 0; i < 2 * plen(s) + 3; i++) begin
        if (i % 9 == 5) step(0, 2'b00, 0, 0, 0, 0, "R6");
        step(1, pat(i + s), 0, 0, 0, 0, "R5");
      end
    end

    // R8: shortcuts with one sample per period
    report_sel = 4'd8;
    step(0, 2'b00, 1, 0, 0, 1, "R8");
    sc_report_disp = 1;
    for (int i = 0; i < 12; i++) step(i % 2 == 0, pat(i), 0, 0, 0, 0, "R8");
    sc_report_disp = 0; sc_report_both = 1;
    for (int i = 0; i < 12; i++) step(i % 2 == 0, pat(i + 3), 0, 0, 0, 0, "R8");
    sc_report_both = 0; sc_double_err = 1;
    for (int i = 0; i < 12; i++) step(i % 3 != 2, (i % 2 == 0) ? 2'b10 : 2'b01, 0, 0, 0, 0, "R8");
    sc_double_err = 0;

    // R10: start mid-period restarts the sample count
    report_sel = 4'd0;
    step(0, 2'b00, 1, 0, 0, 1, "R10");
    for (int i = 0; i < 6; i++) step(1, 2'b01, 0, 0, 0, 0, "R10");
    step(1, 2'b01, 0, 0, 0, 1, "R10");
    for (int i = 0; i < 12; i++) step(1, 2'b00, 0, 0, 0, 0, "R10");
    step(0, 2'b00, 0, 0, 0, 1, "R10");
    for (int i = 0; i < 11; i++) step(1, 2'b10, 0, 0, 0, 0, "R10");

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule